// File: doc/BRIEF.md
# Systolic Serial Bit-Pattern Matcher

This block watches a serial stream of single-bit symbols and raises a one-cycle flag each time the three most recent symbols equal a stored three-bit pattern. The pattern is a parameter, and each of three processing cells holds one bit of it. Stream bits travel forward through the cells, one register per cell. A running "still matching" result travels the other way, also one register per cell. Each cell clears that running result when its stored bit differs from the stream bit it holds. The result that reaches the first cell is the match verdict.

Because the two flows meet head-on, the cells sample stream values two steps apart. The source therefore presents every symbol for two consecutive accepted cycles (s0, s0, s1, s1, ...). This removes any need for signals to reach the cells together, and costs extra latency. An input-valid strobe advances the whole array, so the stream may pause between any two accepted cycles. An internal phase bit tracks which copy of a symbol is being accepted. The verdict is published only on the phase that follows a complete symbol, and only after three complete symbols have been seen.

Top module: `systolic_matcher`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, `match_o` is 0 on the following cycle.
- R2: `match_o` stays 0 until three complete symbols (six accepted cycles) have been taken since reset.
- R3: `match_o` is 1 for exactly the cycle after the accepted cycle that carries the first copy of a symbol, when the three symbols completed before it equal `PATTERN`. `PATTERN[0]` is compared with the newest of those symbols and `PATTERN[2]` with the oldest.
- R4: Under the same timing as R3, `match_o` stays 0 when any of the three completed symbols differs from its `PATTERN` bit.
- R5: A cycle with `bit_valid` low accepts nothing and leaves the array unchanged. `match_o` is 0 in the cycle after it, and the verdicts that follow are the same as if the paused cycle had not occurred.
- R6: `match_o` is never 1 after an accepted second copy of a symbol, so it never stays high for two consecutive cycles.
- R7: Overlapping occurrences are each reported. For the default pattern 101, the symbol run 1,0,1,0,1 gives two flags.
- R8: A reset in mid-stream discards all history. The fill rule of R2 applies again from the next accepted cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial symbol bit; each symbol is offered on two accepted cycles |
| bit_valid | input | 1 | High when `bit_in` is to be accepted on this edge |
| match_o | output | 1 | One-cycle flag: the last three complete symbols equal `PATTERN` |

## Verification
A stream register holding a wrong bit does not show up at once. It surfaces as a missing or spurious flag, and only after the bit has met the counter-flowing result, which takes up to five accepted cycles. A damaged result register shows up on the next publishing phase. A phase bit that slips by one pairs copies of different symbols and misplaces flags by one cycle from then on. A wrong fill count shows up as a flag within the first six accepted cycles. Random streams with random pauses, compared every cycle against a sliding three-symbol window, catch all of these within a few symbols.

// File: rtl/smatch_pkg.sv
// Shared definitions for the systolic bit-pattern matcher.
// Assumes: single-bit symbols; pattern length is fixed at elaboration.
package smatch_pkg;

    // Default number of cells (pattern length).
    localparam int unsigned SM_TAPS_DEFAULT = 3;

    // Default pattern; bit 0 meets the newest symbol.
    localparam logic [SM_TAPS_DEFAULT-1:0] SM_PATTERN_DEFAULT = 3'b101;

    // True when a stream bit agrees with a stored weight bit.
    function automatic logic sm_agree(input logic weight, input logic sample);
        return ~(weight ^ sample);
    endfunction

endpackage

// File: rtl/smatch_cell.sv
// One processing cell of the counterflow matcher.
// Holds one stored weight bit. Registers the stream bit moving forward.
// Registers the partial result moving backward, ANDed with the agreement
// between the weight and the stream bit the cell currently holds.
// Assumes: `adv` is the array-wide step enable; reset is synchronous, active low.
module smatch_cell
    import smatch_pkg::*;
#(
    parameter logic WEIGHT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic stream_in,
    output logic stream_out,
    input  logic part_in,
    output logic part_out
);

    logic stream_q;
    logic part_q;

    // Move the stream bit one cell forward on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)   stream_q <= 1'b0;
        else if (adv) stream_q <= stream_in;
    end

    // Pass the partial result one cell back, cleared on disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n)   part_q <= 1'b0;
        else if (adv) part_q <= part_in & sm_agree(WEIGHT, stream_q);
    end

    assign stream_out = stream_q;
    assign part_out   = part_q;

    // R5
    cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(stream_q) && $stable(part_q)));

    // R4
    cell_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !part_in) |=> !part_out);

endmodule

// File: rtl/smatch_pacer.sv
// Input pacing for the matcher.
// Tracks which copy of a two-cycle symbol is accepted, counts complete
// symbols up to the pattern length, and marks the step whose verdict may be
// published.
// Assumes: every symbol arrives as exactly two accepted cycles; reset is
// synchronous, active low.
module smatch_pacer #(
    parameter int unsigned TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic publish
);

    localparam int unsigned CW = $clog2(TAPS + 1);
    localparam logic [CW-1:0] FULL = CW'(TAPS);

    logic          phase_q;   // 0: first copy is next, 1: second copy is next
    logic [CW-1:0] filled_q;  // completed symbols, saturating at TAPS
    logic          pub_q;

    // Flip the copy phase on every accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   phase_q <= 1'b0;
        else if (adv) phase_q <= ~phase_q;
    end

    // Count completed symbols until the pipeline is full.
    always_ff @(posedge clk) begin
        if (!rst_n)                               filled_q <= '0;
        else if (adv && phase_q && filled_q != FULL) filled_q <= filled_q + 1'b1;
    end

    // Publish on a first-copy step once three symbols are complete.
    always_ff @(posedge clk) begin
        if (!rst_n) pub_q <= 1'b0;
        else        pub_q <= adv && !phase_q && (filled_q == FULL);
    end

    assign publish = pub_q;

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(phase_q));

    // R6
    publish_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        publish |-> ($past(adv) && phase_q));

endmodule

// File: rtl/systolic_matcher.sv
// Top of the systolic serial bit-pattern matcher.
// A chain of TAPS cells: stream enters cell 0 and moves up; the partial
// result enters cell TAPS-1 tied high and moves down; cell 0's result is
// the verdict, gated by the pacer's publish mark.
// Assumes: each symbol is offered on two accepted cycles; PATTERN[0] is
// compared with the newest symbol.
module systolic_matcher
    import smatch_pkg::*;
#(
    parameter int unsigned          NTAPS   = SM_TAPS_DEFAULT,
    parameter logic [NTAPS-1:0]     PATTERN = SM_PATTERN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_valid,
    output logic match_o
);

    logic [NTAPS-1:0] stream_w;
    logic [NTAPS-1:0] part_w;
    logic             publish;

    // Build the cell chain; the end cells take the edge inputs.
    for (genvar i = 0; i < NTAPS; i++) begin : g_cell
        logic s_in;
        logic p_in;
        if (i == 0) begin : g_first
            assign s_in = bit_in;
        end else begin : g_mid
            assign s_in = stream_w[i-1];
        end
        if (i == NTAPS - 1) begin : g_last
            assign p_in = 1'b1;
        end else begin : g_inner
            assign p_in = part_w[i+1];
        end
        smatch_cell #(.WEIGHT(PATTERN[i])) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv       (bit_valid),
            .stream_in (s_in),
            .stream_out(stream_w[i]),
            .part_in   (p_in),
            .part_out  (part_w[i])
        );
    end

    smatch_pacer #(.TAPS(NTAPS)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (bit_valid),
        .publish(publish)
    );

    assign match_o = publish & part_w[0];

    // R5
    match_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(bit_valid));

    // R6
    match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

endmodule

// File: tb/systolic_matcher_tb.sv
module systolic_matcher_tb;

    localparam int unsigned    N   = 3;
    localparam logic [N-1:0]   PAT = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic match_o;

    always #4 clk = ~clk;   // 125 MHz

    systolic_matcher #(.NTAPS(N), .PATTERN(PAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
        .bit_valid(bit_valid), .match_o(match_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    bit       m_phase = 1'b0;
    int       m_filled = 0;
    bit [N-1:0] m_hist = '0;   // bit 0 = newest completed symbol
    bit       exp_next = 1'b0;
    string    lab_next = "R1";
    int       stall_pct = 0;

    // Compute the expected flag for the coming edge from the inputs now driven.
    function automatic void model_step(input bit rst, input bit v, input bit b);
        if (!rst) begin
            exp_next = 1'b0; lab_next = "R1";
            m_phase = 1'b0; m_filled = 0; m_hist = '0;
        end else if (!v) begin
            exp_next = 1'b0; lab_next = "R5";
        end else if (!m_phase) begin
            if (m_filled < N) begin
                exp_next = 1'b0; lab_next = "R2";
            end else begin
                exp_next = (m_hist == PAT);
                lab_next = exp_next ? "R3" : "R4";
            end
            m_phase = 1'b1;
        end else begin
            exp_next = 1'b0; lab_next = "R6";
            m_phase = 1'b0;
            m_hist = {m_hist[N-2:0], b};
            if (m_filled < N) m_filled++;
        end
    endfunction

    // Drive one cycle, then check the flag at the following falling edge.
    task automatic cyc(input bit rst, input bit v, input bit b, input string tag);
        rst_n = rst; bit_valid = v; bit_in = b;
        model_step(rst, v, b);
        @(negedge clk);
        checks++;
        if (match_o !== exp_next) begin
            errors++;
            $display("FAIL %s/%s: match_o=%0b expected=%0b at %0t",
                     lab_next, tag, match_o, exp_next, $time);
        end
    endtask

    // Offer one symbol as two accepted cycles, with optional random pauses.
    task automatic send(input bit b, input string tag);
        for (int c = 0; c < 2; c++) begin
            while (($urandom % 100) < stall_pct) cyc(1'b1, 1'b0, 1'b0, "R5");
            cyc(1'b1, 1'b1, b, tag);
        end
    endtask

    task automatic send_bits(input bit [31:0] bits, input int len, input string tag);
        for (int k = len - 1; k >= 0; k--) send(bits[k], tag);
    endtask

    task automatic do_reset();
        cyc(1'b0, 1'b0, 1'b0, "R1");
        cyc(1'b0, 1'b1, 1'b1, "R1");
    endtask

    initial begin
        void'($urandom(32'd24681357));
        @(negedge clk);
        do_reset();
        // R2: pattern-equal symbols during fill must not flag early.
        send_bits(32'b101, 3, "R2");
        // R3: first flag on next symbol's first copy.
        send_bits(32'b0, 1, "R3");
        // R7: overlapping occurrences of 101.
        send_bits(32'b10101, 5, "R7");
        // R4: all zeros and all ones never match 101.
        send_bits(32'b000000, 6, "R4");
        send_bits(32'b111111, 6, "R4");
        // R5: same patterns with pauses inserted.
        stall_pct = 40;
        send_bits(32'b1010110, 7, "R5");
        // R8: reset in mid-stream after a partial window.
        send_bits(32'b10, 2, "R8");
        do_reset();
        send_bits(32'b1, 1, "R8");
        send_bits(32'b0101, 4, "R8");
        // Random symbols with random pauses.
        stall_pct = 20;
        for (int k = 0; k < 600; k++) send(1'($urandom), "R3");
        stall_pct = 0;
        for (int k = 0; k < 300; k++) send(1'($urandom), "R4");
        send_bits(32'b0, 1, "R6");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: cycles=150000 expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule